// File: doc/BRIEF.md
# One-Hot Statement Sequencer Datapath

This block is the hardware form of a short structured program over three variables `x`, `y` and `z`. Each statement of the program owns one flop in a one-hot token chain. While a statement's flop holds the token, the register of the variable that the statement assigns loads the output of a fixed combinational function of the current variable values. The token moves from flop to flop as the control statements of the program direct. A `start` pulse injects the token. A `cond` input chooses between the two arms of a conditional and decides when a repeat loop exits. The `done` output is high while the token rests in the final statement.

The program runs in this order. First `y := x + F`, then `z := y xor G`, then `x := rotl(z, H)`. Next comes an if/else on `cond`: the then arm sets `y := x + z` and the else arm sets `y := x - z`. Then a repeat-until-`cond` loop runs a parallel statement that sets `x := x + y` and `y := x` at the same time. The program ends in a final state that holds the token. All variables keep their values from one run to the next, so each new run starts from the `x` the previous run left behind.

Top module: `stseq_top`

## Requirements
- R1: During and after reset, every statement enable is 0, `done` is 0, and `var_x`, `var_y` and `var_z` are all 0.
- R2: A `start` that is high while no enable among bits 0..5 is high raises `stmt_en[0]` in the next cycle. A `start` that is high while any of bits 0..5 is high has no effect.
- R3: At most one bit of `stmt_en` is high in any cycle. `stmt_en[1]` follows `stmt_en[0]` by one cycle, and `stmt_en[2]` follows `stmt_en[1]` by one cycle.
- R4: In the cycle after bit 0 is high, `var_y` equals the old `var_x + F_ADD` (mod 2^W). After bit 1, `var_z` equals the old `var_y ^ G_XOR`. After bit 2, `var_x` equals the old `var_z` rotated left by `H_ROT` bits.
- R5: When bit 2 is high, the next enable is bit 3 if `cond` is 1 and bit 4 if `cond` is 0. Bit 3 loads `var_y` with `var_x + var_z`. Bit 4 loads `var_y` with `var_x - var_z` (mod 2^W).
- R6: Bit 3 or bit 4 is always followed by bit 5. While bit 5 is high, `cond` = 0 repeats bit 5 and `cond` = 1 moves the token to bit 6.
- R7: Each cycle with bit 5 high loads `var_x` with the old `var_x + var_y` and `var_y` with the old `var_x`. Both loads use the values from before that cycle.
- R8: A variable register whose statement enables are all low holds its value. `cond` has no effect outside bits 2 and 5.
- R9: `done` is high exactly while bit 6 is high. Bit 6 stays high until a `start` arrives, which moves the token to bit 0 and begins a new run from the current `var_x`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all flops |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Injects the token when no run is in progress |
| cond | input | 1 | Branch select at bit 2, loop exit at bit 5 |
| stmt_en | output | 7 | One-hot statement enables, bit k = statement k |
| done | output | 1 | High while the final statement holds the token |
| var_x | output | W | Register of variable x |
| var_y | output | W | Register of variable y |
| var_z | output | W | Register of variable z |

## Verification
Several corner cases get targeted stimulus. A loop that exits on its first pass checks that the body always runs once; a design that tests the exit before the body would skip the parallel update. The parallel statement is run several times in a row, because a design that updates `x` before `y` reads it would leave `y` equal to the new `x` rather than the old one. Stray `start` pulses in the middle of a run, and a `start` held high across the final state, check that the token never duplicates and that a restart begins cleanly. `cond` toggles in cycles where it has no meaning, so that logic which samples it in the wrong state would send the token down the wrong arm.

// File: rtl/stseq_pkg.sv
package stseq_pkg;
   // statement positions in the token chain; order is the program order
   localparam int ST_FY   = 0;   // y := f(x)
   localparam int ST_GZ   = 1;   // z := g(y)
   localparam int ST_HX   = 2;   // x := h(z), then branch on cond
   localparam int ST_THEN = 3;   // y := x + z
   localparam int ST_ELSE = 4;   // y := x - z
   localparam int ST_LOOP = 5;   // x := x + y || y := x
   localparam int ST_FIN  = 6;   // final, holds token
   localparam int NSTMT   = 7;
   localparam int NSRC_X  = 2;
   localparam int NSRC_Y  = 4;
   localparam int NSRC_Z  = 1;
endpackage

// File: rtl/stseq_token_chain.sv
module stseq_token_chain
   import stseq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cond,
   output logic [NSTMT-1:0] en
);
   logic [NSTMT-1:0] nx;
   logic             busy;

   assign busy = |en[ST_LOOP:ST_FY];

   always_comb begin
      nx          = '0;
      nx[ST_FY]   = start & ~busy;
      nx[ST_GZ]   = en[ST_FY];
      nx[ST_HX]   = en[ST_GZ];
      nx[ST_THEN] = en[ST_HX] & cond;
      nx[ST_ELSE] = en[ST_HX] & ~cond;
      nx[ST_LOOP] = en[ST_THEN] | en[ST_ELSE] | (en[ST_LOOP] & ~cond);
      nx[ST_FIN]  = (en[ST_LOOP] & cond) | (en[ST_FIN] & ~nx[ST_FY]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) en <= '0;
      else        en <= nx;
   end

   AST_TOKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(en)); // R3
   AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n) en[ST_FY] |=> en[ST_GZ]); // R3
   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> en[ST_FY]); // R2
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !en[ST_FY]); // R2
   AST_BRANCH_THEN: assert property (@(posedge clk) disable iff (!rst_n) (en[ST_HX] && cond) |=> en[ST_THEN]); // R5
   AST_BRANCH_ELSE: assert property (@(posedge clk) disable iff (!rst_n) (en[ST_HX] && !cond) |=> en[ST_ELSE]); // R5
   AST_LOOP_AGAIN: assert property (@(posedge clk) disable iff (!rst_n) (en[ST_LOOP] && !cond) |=> en[ST_LOOP]); // R6
   AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n) (en[ST_LOOP] && cond) |=> en[ST_FIN]); // R6
   AST_FIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (en[ST_FIN] && !start) |=> en[ST_FIN]); // R9
   AST_FIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (en[ST_FIN] && start) |=> en[ST_FY]); // R9
endmodule

// File: rtl/stseq_var_reg.sv
module stseq_var_reg #(
   parameter int W    = 8,
   parameter int NSRC = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NSRC-1:0]          sel,
   input  logic [NSRC-1:0][W-1:0]   src,
   output logic [W-1:0]             q
);
   logic [W-1:0] d;
   logic         load;

   if (W < 1)    $error("stseq_var_reg: W must be at least 1");
   if (NSRC < 1) $error("stseq_var_reg: NSRC must be at least 1");

   assign load = |sel;

   if (NSRC == 1) begin : g_single
      assign d = src[0];
   end else begin : g_mux
      // AND-OR select driven straight from the one-hot statement enables
      always_comb begin
         d = '0;
         for (int i = 0; i < NSRC; i++)
            d = d | (src[i] & {W{sel[i]}});
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(q)); // R8
endmodule

// File: rtl/stseq_stmt_alu.sv
module stseq_stmt_alu #(
   parameter int W     = 8,
   parameter int F_ADD = 53,
   parameter int G_XOR = 165,
   parameter int H_ROT = 3
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   output logic [W-1:0] f_out,
   output logic [W-1:0] g_out,
   output logic [W-1:0] h_out,
   output logic [W-1:0] then_out,
   output logic [W-1:0] else_out,
   output logic [W-1:0] loop_x
);
   localparam logic [W-1:0] KF = W'(F_ADD);
   localparam logic [W-1:0] KG = W'(G_XOR);

   if (H_ROT < 0 || H_ROT >= W) $error("stseq_stmt_alu: H_ROT must be in 0..W-1");

   assign f_out    = x + KF;
   assign g_out    = y ^ KG;
   assign then_out = x + z;
   assign else_out = x - z;
   assign loop_x   = x + y;

   if (H_ROT == 0) begin : g_norot
      assign h_out = z;
   end else begin : g_rot
      assign h_out = {z[W-1-H_ROT:0], z[W-1:W-H_ROT]};
   end
endmodule

// File: rtl/stseq_top.sv
module stseq_top
   import stseq_pkg::*;
#(
   parameter int W     = 8,
   parameter int F_ADD = 53,
   parameter int G_XOR = 165,
   parameter int H_ROT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cond,
   output logic [NSTMT-1:0] stmt_en,
   output logic             done,
   output logic [W-1:0]     var_x,
   output logic [W-1:0]     var_y,
   output logic [W-1:0]     var_z
);
   localparam logic [W-1:0] KF = W'(F_ADD);

   if (W < 2) $error("stseq_top: W must be at least 2");

   logic [NSTMT-1:0] en;
   logic [W-1:0]     f_out, g_out, h_out, then_out, else_out, loop_x;

   stseq_token_chain u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .cond  (cond),
      .en    (en)
   );

   stseq_stmt_alu #(.W(W), .F_ADD(F_ADD), .G_XOR(G_XOR), .H_ROT(H_ROT)) u_alu (
      .x        (var_x),
      .y        (var_y),
      .z        (var_z),
      .f_out    (f_out),
      .g_out    (g_out),
      .h_out    (h_out),
      .then_out (then_out),
      .else_out (else_out),
      .loop_x   (loop_x)
   );

   stseq_var_reg #(.W(W), .NSRC(NSRC_X)) u_reg_x (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   ({en[ST_LOOP], en[ST_HX]}),
      .src   ({loop_x, h_out}),
      .q     (var_x)
   );

   stseq_var_reg #(.W(W), .NSRC(NSRC_Y)) u_reg_y (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   ({en[ST_LOOP], en[ST_ELSE], en[ST_THEN], en[ST_FY]}),
      .src   ({var_x, else_out, then_out, f_out}),
      .q     (var_y)
   );

   stseq_var_reg #(.W(W), .NSRC(NSRC_Z)) u_reg_z (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (en[ST_GZ]),
      .src   (g_out),
      .q     (var_z)
   );

   assign stmt_en = en;
   assign done    = en[ST_FIN];

   AST_F_LOAD: assert property (@(posedge clk) disable iff (!rst_n) en[ST_FY] |=> (var_y == W'($past(var_x) + KF))); // R4
   AST_PAR_OLD: assert property (@(posedge clk) disable iff (!rst_n) en[ST_LOOP] |=> (var_y == $past(var_x))); // R7
   AST_PAR_SUM: assert property (@(posedge clk) disable iff (!rst_n) en[ST_LOOP] |=> (var_x == W'($past(var_x) + $past(var_y)))); // R7
   AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !en[ST_GZ] |=> $stable(var_z)); // R8
endmodule

// File: tb/sim_stseq_top.sv
module sim_stseq_top;
   localparam int W  = 8;
   localparam int FA = 53;
   localparam int GX = 165;
   localparam int HR = 3;
   localparam int NS = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          cond = 1'b0;
   logic [NS-1:0] stmt_en;
   logic          done;
   logic [W-1:0]  var_x, var_y, var_z;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // reference model: token position as integer, -1 = idle
   int           mpos = -1;
   logic [W-1:0] mx = '0, my = '0, mz = '0;

   int plan_then = 1;
   int plan_loops = 0;
   int loop_cnt = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   stseq_top #(.W(W), .F_ADD(FA), .G_XOR(GX), .H_ROT(HR)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cond(cond),
      .stmt_en(stmt_en), .done(done),
      .var_x(var_x), .var_y(var_y), .var_z(var_z)
   );

   function automatic logic [W-1:0] rotl(input logic [W-1:0] v);
      return (v << HR) | (v >> (W - HR));
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mpos <= -1; mx <= '0; my <= '0; mz <= '0;
      end else begin
         case (mpos)
            0: my <= mx + W'(FA);
            1: mz <= my ^ W'(GX);
            2: mx <= rotl(mz);
            3: my <= mx + mz;
            4: my <= mx - mz;
            5: begin mx <= mx + my; my <= mx; end
            default: ;
         endcase
         if (start && !(mpos >= 0 && mpos <= 5)) mpos <= 0;
         else case (mpos)
            0: mpos <= 1;
            1: mpos <= 2;
            2: mpos <= cond ? 3 : 4;
            3, 4: mpos <= 5;
            5: mpos <= cond ? 6 : 5;
            default: ;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         logic [NS-1:0] exp_en;
         exp_en = (mpos >= 0) ? NS'(1 << mpos) : '0;
         chk(stmt_en == exp_en, "R2 R3 R5 R6 enables", stmt_en, exp_en);
         chk($countones(stmt_en) <= 1, "R3 one-hot", $countones(stmt_en), 1);
         chk(done == (mpos == 6), "R9 done", done, (mpos == 6));
         chk(var_x == mx, "R4 R7 R8 var_x", var_x, mx);
         chk(var_y == my, "R4 R5 R7 R8 var_y", var_y, my);
         chk(var_z == mz, "R4 R8 var_z", var_z, mz);
      end
   end

   // one cycle of stimulus: cond from the plan where it matters, noise elsewhere
   task automatic step(input bit poke_busy);
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (mpos == 2) cond = plan_then[0];
      else if (mpos == 5) begin
         cond = (loop_cnt >= plan_loops);
         loop_cnt++;
      end else cond = cyc[0]; // R8: no effect here
      if (poke_busy && mpos >= 0 && mpos <= 5 && cyc[1]) start = 1'b1; // R2 ignored
   endtask

   task automatic run(input int th, input int loops, input bit poke, input bit hold_start);
      plan_then = th; plan_loops = loops; loop_cnt = 0;
      @(negedge clk);
      start = 1'b1;
      cond = ~cond;
      for (int i = 0; i < 60 && mpos != 6; i++) step(poke);
      if (hold_start) begin
         @(negedge clk);
         start = 1'b1; // R9 restart from final state
      end else begin
         for (int i = 0; i < 3; i++) step(1'b0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(stmt_en == '0, "R1 enables", stmt_en, 0);
      chk(done == 1'b0, "R1 done", done, 0);
      chk({var_x, var_y, var_z} == '0, "R1 vars", {var_x, var_y, var_z}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) step(1'b0);
      run(1, 0, 1'b0, 1'b0);   // then arm, loop exits on first pass
      run(0, 3, 1'b1, 1'b0);   // else arm, several passes, stray starts
      run(1, 2, 1'b1, 1'b1);   // restart held through final state
      plan_then = 0; plan_loops = 1; loop_cnt = 0;
      for (int i = 0; i < 40 && mpos != 6; i++) step(1'b0);
      run(0, 0, 1'b0, 1'b0);
      for (int r = 0; r < 6; r++) run(r % 2, r, r[0], r == 4);
      for (int i = 0; i < 5; i++) step(1'b0);
      chk(done == 1'b1, "R9 final holds", done, 1);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule